// File: doc/BRIEF.md
# Global Data Memory Window Arbiter

This block sits beside a CPU on its 16-bit data-memory bus and sorts every data access into one of two kinds: local or global. The highest part of the 64K-word data space may be set aside as shared external memory. Software sets the size of that part at run time through an 8-bit allocation register.

Accesses below the global window complete at once. An access inside the window triggers three steps. The block asserts a bus request and holds the CPU with a ready-low stall until the shared bus is granted. It then drives the external strobe for exactly one cycle.

The request stays asserted for one cycle after each external access. If the CPU's next access is also global, the bus is never let go in between.

Top module: `gwa_top`

## Requirements
- R1: After reset the allocation register holds zero, `bus_req` and `ext_strb` are low, and every access, including address 0xFFFF, completes locally.
- R2: A legal nonzero allocation value has k ones packed from bit 7 downward (1 ≤ k ≤ 8). With such a value, an address is global when its upper 8 bits have ones at every position set in the value. This makes the window the top 2^(16-k) words: 0x80 gives 32K words from 0x8000, 0xF0 gives 4K words from 0xF000, and 0xFF gives 256 words from 0xFF00. A write takes effect in the cycle after it is made.
- R3: Zero disables the window. Any value whose ones are not packed from bit 7 downward is stored as zero (for example 0x40, 0xA0 or 0x7F), so all accesses stay local.
- R4: A local access sees `cpu_rdy` high in the cycle it is presented, and `bus_req` and `ext_strb` stay low.
- R5: For a global access presented while the bus is idle, `cpu_rdy` is low in the cycle it is presented. `bus_req` rises in the next cycle. `cpu_rdy` stays low for as long as no grant has been sampled.
- R6: `ext_strb` is high for exactly one cycle, the cycle after a clock edge at which `bus_req` and `bus_gnt` were both high. `cpu_rdy` is high in that cycle, so the access completes there.
- R7: `bus_req` stays high for the one cycle after the strobe cycle. It then drops, unless a global access is presented in that cycle.
- R8: A global access presented in the cycle after a strobe keeps `bus_req` high. If the grant is still held, its strobe follows in the next cycle. Otherwise the block waits for the grant as in R5.
- R9: `bus_gnt` has no effect while `bus_req` is low: no strobe occurs.
- R10: During the strobe, `ext_addr` and `ext_we` carry the CPU's address and write flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU data access valid, held until `cpu_rdy` |
| cpu_addr | input | 16 | CPU word address |
| cpu_we | input | 1 | CPU access is a write |
| cpu_rdy | output | 1 | Access completes at this clock edge |
| cfg_we | input | 1 | Write strobe for the allocation register |
| cfg_wdata | input | 8 | Allocation value |
| bus_req | output | 1 | Shared bus request |
| bus_gnt | input | 1 | Shared bus grant |
| ext_strb | output | 1 | External memory cycle strobe |
| ext_addr | output | 16 | External address |
| ext_we | output | 1 | External write flag |

## Verification
The bench builds the block with its default 16-bit address and 8-bit allocation register. At these values all eight legal window sizes can be reached, and the bench probes the boundary addresses of the smallest, a middle and the largest window. Grant waits of zero and several cycles are driven. So are back-to-back global accesses that both keep and lose the grant, and stray grants while the bus is idle.

// File: rtl/gwa_pkg.sv
package gwa_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_REQ    = 2'd1,
    ARB_XFER   = 2'd2,
    ARB_LINGER = 2'd3
  } arb_state_t;
endpackage

// File: rtl/gwa_alloc_reg.sv
module gwa_alloc_reg #(
  parameter int ALLOC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ALLOC_W-1:0] wr_data,
  output logic [ALLOC_W-1:0] win_mask,
  output logic               win_en
);
  logic [ALLOC_W-1:0] alloc_q, alloc_d;
  logic [ALLOC_W-1:0] inv_v, inv_inc;
  logic               packed_ok;

  // ones packed from the top <=> inverted value is a run of low ones
  always_comb begin
    inv_v     = ~wr_data;
    inv_inc   = inv_v + ALLOC_W'(1);
    packed_ok = ((inv_v & inv_inc) == '0);
    alloc_d   = alloc_q;
    if (wr_en) alloc_d = packed_ok ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alloc_q <= '0;
    else        alloc_q <= alloc_d;
  end

  assign win_mask = alloc_q;
  assign win_en   = (alloc_q != '0);
endmodule

// File: rtl/gwa_window_dec.sv
module gwa_window_dec #(
  parameter int ADDR_W  = 16,
  parameter int ALLOC_W = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ALLOC_W-1:0] win_mask,
  input  logic               win_en,
  output logic               hit
);
  localparam int TOP_LSB = ADDR_W - ALLOC_W;
  logic [ALLOC_W-1:0] bit_ok;

  for (genvar i = 0; i < ALLOC_W; i++) begin : g_bit
    assign bit_ok[i] = ~win_mask[i] | addr[TOP_LSB + i];
  end

  assign hit = win_en & (&bit_ok);
endmodule

// File: rtl/gwa_arb_fsm.sv
module gwa_arb_fsm
  import gwa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic glob_acc,
  input  logic bus_gnt,
  output logic bus_req,
  output logic xfer
);
  arb_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_IDLE:   if (glob_acc) st_d = ARB_REQ;
      ARB_REQ:    if (bus_gnt)  st_d = ARB_XFER;
      ARB_XFER:   st_d = ARB_LINGER;
      ARB_LINGER: begin
        if (glob_acc) st_d = bus_gnt ? ARB_XFER : ARB_REQ;
        else          st_d = ARB_IDLE;
      end
      default:    st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end

  assign bus_req = (st_q != ARB_IDLE);
  assign xfer    = (st_q == ARB_XFER);
endmodule

// File: rtl/gwa_top.sv
module gwa_top #(
  parameter int ADDR_W  = 16,
  parameter int ALLOC_W = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_we,
  output logic               cpu_rdy,
  input  logic               cfg_we,
  input  logic [ALLOC_W-1:0] cfg_wdata,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               ext_strb,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic               ext_we
);
  logic [SYNC_N-1:0]  rst_pipe;
  logic               rst_sync_n;
  logic [ALLOC_W-1:0] win_mask;
  logic               win_en;
  logic               hit;
  logic               glob_acc;
  logic               xfer;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  gwa_alloc_reg #(.ALLOC_W(ALLOC_W)) i_alloc (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .win_mask(win_mask), .win_en(win_en)
  );

  gwa_window_dec #(.ADDR_W(ADDR_W), .ALLOC_W(ALLOC_W)) i_dec (
    .addr(cpu_addr), .win_mask(win_mask), .win_en(win_en), .hit(hit)
  );

  assign glob_acc = cpu_req & hit;

  gwa_arb_fsm i_fsm (
    .clk(clk), .rst_n(rst_sync_n), .glob_acc(glob_acc), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .xfer(xfer)
  );

  assign cpu_rdy  = ~glob_acc | xfer;
  assign ext_strb = xfer;
  assign ext_addr = cpu_addr;
  assign ext_we   = cpu_we;
endmodule

// File: rtl/gwa_chk.sv
module gwa_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_req,
  input logic cpu_rdy,
  input logic bus_req,
  input logic bus_gnt,
  input logic ext_strb
);
  // R9
  strb_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strb |-> bus_req);
  // R6
  strb_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strb |-> ($past(bus_gnt) && $past(bus_req)));
  // R6
  strb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strb |=> !ext_strb);
  // R6
  strb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strb |-> cpu_rdy);
  // R7
  req_drop_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(ext_strb, 2));
  // R5
  stall_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && $rose(bus_req)) |-> !cpu_rdy);
endmodule

bind gwa_top gwa_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_req(cpu_req), .cpu_rdy(cpu_rdy),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .ext_strb(ext_strb)
);

// File: tb/test_gwa_top.sv
module test_gwa_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_rdy;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic        ext_strb;
  logic [15:0] ext_addr;
  logic        ext_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gwa_top i_gwa_top (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_rdy(cpu_rdy), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .ext_strb(ext_strb),
    .ext_addr(ext_addr), .ext_we(ext_we)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] v);
    @(negedge clk);
    cpu_req = 1'b0; cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic local_access(logic [15:0] a, string req);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_we = 1'b0;
    #1;
    chk(req, "local rdy", cpu_rdy, 1);
    chk(req, "local bus_req", bus_req, 0);
    chk(req, "local strb", ext_strb, 0);
  endtask

  // presents a global access from idle; returns after checking the strobe cycle
  task automatic glob_access(logic [15:0] a, logic we, int wait_n, string req);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_we = we; bus_gnt = 1'b0;
    #1;
    chk("R5", "present rdy", cpu_rdy, 0);
    chk("R5", "present bus_req", bus_req, 0);
    for (int i = 0; i <= wait_n; i++) begin
      @(negedge clk); #1;
      chk("R5", "wait bus_req", bus_req, 1);
      chk("R5", "wait rdy", cpu_rdy, 0);
      chk("R6", "wait strb", ext_strb, 0);
      if (i == wait_n) bus_gnt = 1'b1;
    end
    @(negedge clk); #1;
    chk("R6", "strobe", ext_strb, 1);
    chk("R6", "strobe rdy", cpu_rdy, 1);
    chk("R10", "ext_addr", ext_addr, a);
    chk("R10", "ext_we", ext_we, we);
    chk(req, "window hit", ext_strb, 1);
  endtask

  task automatic release_bus;
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0;
    #1;
    chk("R7", "linger bus_req", bus_req, 1);
    chk("R6", "single strobe", ext_strb, 0);
    @(negedge clk); #1;
    chk("R7", "released", bus_req, 0);
  endtask

  task automatic t_reset;
    chk("R1", "reset bus_req", bus_req, 0);
    chk("R1", "reset strb", ext_strb, 0);
    local_access(16'hFFFF, "R1");
    local_access(16'h0000, "R4");
  endtask

  task automatic t_windows;
    cfg_write(8'h80);
    local_access(16'h7FFF, "R2");
    glob_access(16'h8000, 1'b1, 0, "R2");
    release_bus();
    cfg_write(8'hFF);
    local_access(16'hFEFF, "R2");
    glob_access(16'hFF00, 1'b0, 2, "R2");
    release_bus();
    cfg_write(8'hF0);
    local_access(16'hEFFF, "R2");
    glob_access(16'hF123, 1'b1, 4, "R2");
    release_bus();
  endtask

  task automatic t_illegal;
    cfg_write(8'h40);
    local_access(16'hFFFF, "R3");
    cfg_write(8'hA0);
    local_access(16'hFFFF, "R3");
    cfg_write(8'h7F);
    local_access(16'hFF80, "R3");
    cfg_write(8'h00);
    local_access(16'hFFFF, "R3");
  endtask

  task automatic t_local_run;
    cfg_write(8'hC0);
    for (int k = 0; k < 6; k++) local_access(16'(k * 16'h2000), "R4");
  endtask

  task automatic t_back_to_back;
    cfg_write(8'hC0);
    glob_access(16'hC010, 1'b0, 1, "R8");
    @(negedge clk);
    cpu_addr = 16'hD020; cpu_we = 1'b1;
    #1;
    chk("R8", "second stall", cpu_rdy, 0);
    chk("R8", "req held", bus_req, 1);
    @(negedge clk); #1;
    chk("R8", "second strobe", ext_strb, 1);
    chk("R8", "second addr", ext_addr, 16'hD020);
    chk("R8", "req still held", bus_req, 1);
    release_bus();
  endtask

  task automatic t_linger_regrant;
    glob_access(16'hE000, 1'b0, 0, "R8");
    @(negedge clk);
    cpu_addr = 16'hE004; bus_gnt = 1'b0;
    #1;
    chk("R8", "regrant stall", cpu_rdy, 0);
    @(negedge clk); #1;
    chk("R8", "regrant req", bus_req, 1);
    chk("R8", "regrant no strb", ext_strb, 0);
    bus_gnt = 1'b1;
    @(negedge clk); #1;
    chk("R8", "regrant strobe", ext_strb, 1);
    release_bus();
  endtask

  task automatic t_stray_grant;
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R9", "stray strb", ext_strb, 0);
      chk("R9", "stray req", bus_req, 0);
    end
    bus_gnt = 1'b0;
    local_access(16'h1234, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_windows();
    t_illegal();
    t_local_run();
    t_back_to_back();
    t_linger_regrant();
    t_stray_grant();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule